// File: doc/BRIEF.md
# Multi-Precision Sub-Word Multiplier

This block multiplies two 32-bit operand words. A 3-bit mode code chooses how the words are split into lanes. Three modes give independent real products: one 32×32, two 16×16 or four 8×8, each signed or unsigned. Two further modes give complex products: one product with 16-bit parts, or two in parallel with 8-bit parts. Every result is packed into a single 64-bit word.

All modes share one partial-product generator and one accumulation array. Every partial-product bit has a validity flag, and only valid bits enter the sum. The sum breaks its carry chain at each result-field boundary, so one lane never disturbs another.

The datapath has two register stages. The operands and controls are captured on the first edge. The masked partial-product array is then reduced, and the result is registered on the second edge. There is no control state machine: a valid bit travels down the pipeline with the data, and one operation can be accepted in every cycle.

Top module: `simd_mul`

## Requirements
- R1: Mode code 3'b000 produces the 64-bit product of op_a and op_b in result[63:0].
- R2: Mode code 3'b001 treats bits [16i+15:16i] of each operand as lane i (i = 0..1). It places the 32-bit product of lane i at result[32i+31:32i].
- R3: Mode code 3'b010 treats bits [8i+7:8i] of each operand as lane i (i = 0..3). It places the 16-bit product of lane i at result[16i+15:16i].
- R4: In the three real modes, is_signed = 1 treats every lane as a two's complement value, and is_signed = 0 treats it as unsigned.
- R5: Mode code 3'b011 is a complex product. The real parts ar and br are in bits [15:0] and the imaginary parts ai and bi are in bits [31:16]. ar·br − ai·bi goes to result[31:0] and ar·bi + ai·br goes to result[63:32].
- R6: Mode code 3'b100 runs two complex products in parallel. Complex lane k (k = 0..1) uses operand bits [16k+7:16k] as the real part and [16k+15:16k+8] as the imaginary part. Its real result goes to result[32k+15:32k] and its imaginary result goes to result[32k+31:32k+16].
- R7: Both complex modes always treat their parts as two's complement. The value of is_signed has no effect on them.
- R8: Mode codes 3'b101, 3'b110 and 3'b111 return a result of zero, with out_valid still raised.
- R9: An operation presented with in_valid = 1 in cycle t gives out_valid = 1 and its result in cycle t+2. Operations may be presented in consecutive cycles.
- R10: out_valid is high for exactly one cycle per accepted operation. While out_valid is low, result keeps its last value.
- R11: rst_n low at a clock edge clears out_valid and result to zero.
- R12: Each result field holds its exact value modulo 2^(field width). No carry passes from one field into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| mode | input | 3 | Lane split and operation selector |
| is_signed | input | 1 | Two's complement lanes in the real modes |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| out_valid | output | 1 | Result present, two cycles after in_valid |
| result | output | 64 | Packed lane results |

## Verification
Lanes filled with all ones are checked in signed and unsigned form. Signed all-ones gives a product of 1, while unsigned all-ones gives a product close to full scale, so a mishandled top multiplier row shows up at once. Lanes of 0xFF per byte give the largest per-field sums, so a carry that leaks across a field boundary corrupts the neighbouring field. Complex operands at the most negative value check the subtraction and the modulo wrap of the real part, and mixed-sign parts show whether the real and imaginary fields were placed or swapped correctly. Seeded random words cover all eight mode codes under both signedness settings. Back-to-back issue and idle gaps confirm the two-cycle latency and that the result holds between operations.

// File: rtl/smul_pkg.sv
package smul_pkg;
    localparam int OPW_DEF = 32;

    typedef enum logic [2:0] {
        MD_R32 = 3'd0,
        MD_R16 = 3'd1,
        MD_R8  = 3'd2,
        MD_C16 = 3'd3,
        MD_C8  = 3'd4
    } smul_mode_e;
endpackage

// File: rtl/smul_ppgen.sv
module smul_ppgen
    import smul_pkg::*;
#(
    parameter int OPW  = OPW_DEF,
    parameter int RW   = 2 * OPW,
    parameter int ROWS = OPW
) (
    input  logic [2:0]               mode,
    input  logic                     sgn,
    input  logic [OPW-1:0]           opa,
    input  logic [OPW-1:0]           opb,
    output logic [ROWS-1:0][RW-1:0]  pp,
    output logic [ROWS-1:0][RW-1:0]  vld,
    output logic [RW-1:0]            corr,
    output logic [RW-1:0]            cut
);
    localparam int MAXF = 4;

    function automatic logic [RW-1:0] lomask(input int w);
        return (w >= RW) ? '1 : ((RW'(1) << w) - RW'(1));
    endfunction

    function automatic logic [RW-1:0] sext(input logic [RW-1:0] v, input int w, input logic s);
        logic [RW-1:0] m;
        logic [RW-1:0] t;
        m = lomask(w);
        t = v & m;
        if (s && t[w-1]) t = t | ~m;
        return t;
    endfunction

    int            nf, n, off, base, cnt, nterms, r;
    logic          cplx, sg, ng1, ng2, ng, qb;
    logic [RW-1:0] av, bv, fm, m1, m2, q1, q2, v;

    always_comb begin
        for (int i = 0; i < ROWS; i++) begin
            pp[i]  = '0;
            vld[i] = '0;
        end
        corr = '0; cut = '0;
        nf = 0; n = 1; cplx = 1'b0; sg = sgn;
        off = 0; base = 0; cnt = 0; nterms = 1; r = 0;
        ng1 = 1'b0; ng2 = 1'b0; ng = 1'b0; qb = 1'b0;
        fm = '0; m1 = '0; m2 = '0; q1 = '0; q2 = '0; v = '0;
        av = RW'(opa);
        bv = RW'(opb);
        unique case (smul_mode_e'(mode))
            MD_R32:  begin nf = 1; n = OPW;     end
            MD_R16:  begin nf = 2; n = OPW / 2; end
            MD_R8:   begin nf = 4; n = OPW / 4; end
            MD_C16:  begin nf = 2; n = OPW / 2; cplx = 1'b1; sg = 1'b1; end
            MD_C8:   begin nf = 4; n = OPW / 4; cplx = 1'b1; sg = 1'b1; end
            default: begin nf = 0; end
        endcase
        for (int f = 0; f < MAXF; f++) begin
            if (f < nf) begin
                off = f * 2 * n;
                fm  = lomask(2 * n);
                cut[off] = 1'b1;
                cnt = 0;
                if (!cplx) begin
                    m1 = sext(av >> (f * n), n, sg);
                    q1 = bv >> (f * n);
                    ng1 = 1'b0; m2 = '0; q2 = '0; ng2 = 1'b0;
                    nterms = 1;
                end else begin
                    base = (f / 2) * 2 * n;
                    m1 = sext(av >> base, n, 1'b1);
                    m2 = sext(av >> (base + n), n, 1'b1);
                    ng1 = 1'b0;
                    if (f % 2 == 0) begin
                        q1 = bv >> base;        // real field: ar*br - ai*bi
                        q2 = bv >> (base + n);
                        ng2 = 1'b1;
                    end else begin
                        q1 = bv >> (base + n);  // imag field: ar*bi + ai*br
                        q2 = bv >> base;
                        ng2 = 1'b0;
                    end
                    nterms = 2;
                end
                for (int j = 0; j < ROWS; j++) begin
                    for (int t = 0; t < 2; t++) begin
                        if (j < n && t < nterms) begin
                            r  = t * n + j;
                            qb = (t == 0) ? q1[j] : q2[j];
                            ng = ((t == 0) ? ng1 : ng2) ^ (sg && (j == n - 1));
                            v  = qb ? ((((t == 0) ? m1 : m2) << j) & fm) : '0;
                            if (ng) begin
                                v   = ~v & fm;
                                cnt = cnt + 1;
                            end
                            pp[r]  = pp[r] | (v << off);
                            vld[r] = vld[r] | (fm << off);
                        end
                    end
                end
                corr = corr | ((RW'(cnt) & fm) << off);
            end
        end
    end
endmodule

// File: rtl/smul_accum.sv
module smul_accum #(
    parameter int RW   = 64,
    parameter int ROWS = 32
) (
    input  logic [ROWS-1:0][RW-1:0] pp,
    input  logic [ROWS-1:0][RW-1:0] vld,
    input  logic [RW-1:0]           corr,
    input  logic [RW-1:0]           cut,
    output logic [RW-1:0]           sum
);
    function automatic logic [RW-1:0] seg_add(input logic [RW-1:0] x,
                                              input logic [RW-1:0] y,
                                              input logic [RW-1:0] brk);
        logic          c;
        logic [RW-1:0] s;
        c = 1'b0;
        s = '0;
        for (int k = 0; k < RW; k++) begin
            if (brk[k]) c = 1'b0;
            s[k] = x[k] ^ y[k] ^ c;
            c    = (x[k] & y[k]) | (c & (x[k] ^ y[k]));
        end
        return s;
    endfunction

    logic [RW-1:0] acc;

    always_comb begin
        acc = corr;
        for (int r = 0; r < ROWS; r++) begin
            acc = seg_add(acc, pp[r] & vld[r], cut);
        end
        sum = acc;
    end
endmodule

// File: rtl/simd_mul.sv
module simd_mul
    import smul_pkg::*;
#(
    parameter int OPW = OPW_DEF,
    localparam int RW = 2 * OPW,
    localparam int ROWS = OPW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [2:0]     mode,
    input  logic           is_signed,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    output logic           out_valid,
    output logic [RW-1:0]  result
);
    logic           v1_q, s1_q;
    logic [2:0]     m1_q;
    logic [OPW-1:0] a1_q, b1_q;

    logic [ROWS-1:0][RW-1:0] pp_w, vld_w;
    logic [RW-1:0]           corr_w, cut_w, sum_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            s1_q <= 1'b0;
            m1_q <= '0;
            a1_q <= '0;
            b1_q <= '0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                s1_q <= is_signed;
                m1_q <= mode;
                a1_q <= op_a;
                b1_q <= op_b;
            end
        end
    end

    smul_ppgen #(.OPW(OPW), .RW(RW), .ROWS(ROWS)) u_ppgen (
        .mode (m1_q),
        .sgn  (s1_q),
        .opa  (a1_q),
        .opb  (b1_q),
        .pp   (pp_w),
        .vld  (vld_w),
        .corr (corr_w),
        .cut  (cut_w)
    );

    smul_accum #(.RW(RW), .ROWS(ROWS)) u_accum (
        .pp   (pp_w),
        .vld  (vld_w),
        .corr (corr_w),
        .cut  (cut_w),
        .sum  (sum_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= v1_q;
            if (v1_q) result <= sum_w;
        end
    end

    // R9
    latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R10
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |-> $stable(result));

    // R8
    bad_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode > 3'd4) |-> ##2 (result == '0));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));
endmodule

// File: tb/tb_simd_mul.sv
`timescale 1ns/1ps
module tb_simd_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        is_signed = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    simd_mul dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .is_signed(is_signed), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result)
    );

    function automatic longint mk(input int w);
        return (w >= 64) ? -64'sd1 : ((64'sd1 <<< w) - 64'sd1);
    endfunction

    function automatic longint fld(input logic [31:0] v, input int pos, input int w, input bit s);
        longint t;
        t = longint'({32'd0, v} >> pos) & mk(w);
        if (s && t[w-1]) t = t - (64'sd1 <<< w);
        return t;
    endfunction

    function automatic logic [63:0] ref_mul(input logic [2:0] m, input bit s,
                                            input logic [31:0] a, input logic [31:0] b);
        logic [63:0] r;
        longint x, y, ar, ai, br, bi, re, im;
        int n;
        r = '0;
        if (m <= 3'd2) begin
            n = 32 >> m;
            for (int i = 0; i < (1 << m); i++) begin
                x = fld(a, i * n, n, s);
                y = fld(b, i * n, n, s);
                r = r | (64'((x * y) & mk(2 * n)) << (i * 2 * n));
            end
        end else if (m <= 3'd4) begin
            n = (m == 3'd3) ? 16 : 8;
            for (int k = 0; k < 32 / (2 * n); k++) begin
                ar = fld(a, k * 2 * n, n, 1'b1);
                ai = fld(a, k * 2 * n + n, n, 1'b1);
                br = fld(b, k * 2 * n, n, 1'b1);
                bi = fld(b, k * 2 * n + n, n, 1'b1);
                re = ar * br - ai * bi;
                im = ar * bi + ai * br;
                r = r | (64'(re & mk(2 * n)) << (k * 4 * n));
                r = r | (64'(im & mk(2 * n)) << (k * 4 * n + 2 * n));
            end
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // one operation, driven at a falling edge, result sampled two falling edges later
    task automatic do_op(input logic [2:0] m, input bit s, input logic [31:0] a,
                         input logic [31:0] b, input string req);
        logic [63:0] e;
        e = ref_mul(m, s, a, b);
        mode = m; is_signed = s; op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({"R9 early ", req}, {64'd0, out_valid}, 65'd0);
        @(negedge clk);
        chk(req, {out_valid, result}, {1'b1, e});
    endtask

    initial begin
        logic [63:0] e1, e2, last;
        logic [2:0]  rm;
        bit          rs;
        logic [31:0] ra, rb;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        // R11: reset clears outputs
        chk("R11", {out_valid, result}, 65'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R4: full width, both signedness settings
        do_op(3'd0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 R4 signed -1*-1");
        do_op(3'd0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 R4 unsigned max");
        do_op(3'd0, 1'b1, 32'h8000_0000, 32'h8000_0000, "R1 R4 signed min*min");
        // R2 / R4
        do_op(3'd1, 1'b1, 32'hFFFF_8000, 32'h0003_8000, "R2 R4 signed lanes");
        do_op(3'd1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 R12 unsigned max");
        // R3 / R12: 0xFF lanes, carry must stay inside each field
        do_op(3'd2, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 R12 unsigned 0xFF");
        do_op(3'd2, 1'b1, 32'h807F_FF80, 32'h80FF_7F80, "R3 R4 signed mix");
        // R5 / R7: complex 16-bit, signedness flag must not matter
        do_op(3'd3, 1'b0, 32'h8000_8000, 32'h8000_7FFF, "R5 R7 flag0 min");
        do_op(3'd3, 1'b1, 32'h8000_8000, 32'h8000_7FFF, "R5 R7 flag1 min");
        do_op(3'd3, 1'b0, 32'h0003_FFFE, 32'hFFFB_0007, "R5 R7 mixed parts");
        // R6 / R7
        do_op(3'd4, 1'b0, 32'h80FF_7F01, 32'h8080_FF7F, "R6 R7 two lanes");
        // R8: unsupported codes after a nonzero result
        do_op(3'd0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, "R1 pre");
        do_op(3'd5, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 code5");
        do_op(3'd7, 1'b1, 32'h1234_5678, 32'h0000_0011, "R8 code7");

        // R10: result holds while idle
        do_op(3'd2, 1'b0, 32'h0102_0304, 32'h0506_0708, "R3 hold setup");
        last = ref_mul(3'd2, 1'b0, 32'h0102_0304, 32'h0506_0708);
        repeat (3) begin
            @(negedge clk);
            chk("R10 hold", {out_valid, result}, {1'b0, last});
        end

        // R9: back-to-back issue
        e1 = ref_mul(3'd1, 1'b1, 32'hABCD_1234, 32'h5678_FEDC);
        e2 = ref_mul(3'd4, 1'b0, 32'h1122_3344, 32'h5566_7788);
        mode = 3'd1; is_signed = 1'b1; op_a = 32'hABCD_1234; op_b = 32'h5678_FEDC; in_valid = 1'b1;
        @(negedge clk);
        mode = 3'd4; is_signed = 1'b0; op_a = 32'h1122_3344; op_b = 32'h5566_7788;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 back-to-back first", {out_valid, result}, {1'b1, e1});
        @(negedge clk);
        chk("R9 back-to-back second", {out_valid, result}, {1'b1, e2});
        @(negedge clk);
        chk("R10 single pulse", {64'd0, out_valid}, 65'd0);

        // random mix over all codes
        for (int i = 0; i < 300; i++) begin
            rm = 3'($urandom % 8);
            rs = 1'($urandom % 2);
            ra = $urandom;
            rb = $urandom;
            do_op(rm, rs, ra, rb, {tag_of(rm), (rm <= 3'd2) ? " R4 R12 random" : " random"});
        end

        // R11: reset in the middle of an operation clears outputs
        mode = 3'd0; op_a = 32'h7; op_b = 32'h9; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R11 mid-run", {out_valid, result}, 65'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after", {out_valid, result}, 65'd0);

        done = 1'b1;
        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            finish_up();
        end
    end
endmodule